// File: doc/BRIEF.md
# Prioritised Interrupt Concentrator

This block collects 64 level-sensitive interrupt lines and reduces them to a single outstanding interrupt-vector request. Lines 0 to 31 come from expansion-bus (PCI) slots. Lines 32 to 63 come from on-board peripherals, and their vector number is the line index with bit 5 set. Exactly one request output exists for each vector number, and at most one of them is driven at any time. The request stays driven until software clears it.

Software controls the block through a word-wide register port. Each group of four slot lines shares one map register, and each on-board line has its own. Only bit 31 of a map register, the enable, can be written. Two clear windows let software retire the pending request: one matches by slot group and the other matches by exact vector.

Whenever a map write or a successful clear triggers re-evaluation, a fixed-priority scan picks the lowest-numbered asserted and enabled line. Slot lines are scanned before on-board lines. A slot line that rises while enabled pre-empts whatever is pending. An on-board line that rises is accepted only when nothing is pending.

Top module: `irq_concentrator`

## Requirements
- R1: After reset no request output is driven, slot map register k (address 0x0C00 + 4k, k = 0..7) reads 0, and on-board map register i (address 0x1000 + 4i, i = 0..31) reads 0x7E0 + i.
- R2: A write to any map register changes only bit 31, the enable, and bits 30:0 read back unchanged.
- R3: At most one bit of the 64-bit request output is set in any cycle.
- R4: When a slot line rises and its group's enable is set, that line's vector is driven from the next cycle and replaces any pending request. If several such lines rise in the same cycle, the lowest index wins.
- R5: An on-board line that rises with its enable set becomes the request only if nothing is pending. Otherwise the rise is ignored.
- R6: A line falling does not withdraw a request that is already pending.
- R7: Writing a map register with bit 31 clear, while the pending vector belongs to that register, drops the request and starts a rescan.
- R8: A write to 0x1400..0x14FF with address bit 2 set clears the request when address bits 7:5 equal the pending vector divided by 4, and then rescans. With bit 2 clear, or with no match, the write has no effect.
- R9: A write to 0x1800..0x18FF with address bit 2 set forms the vector {1, addr[7:3]}. It clears the request and rescans only on an exact match with the pending vector. With bit 2 clear, or with a mismatch, nothing happens.
- R10: Every map write rescans. A rescan keeps a pending request as it is. Otherwise it selects the lowest asserted and enabled line, scanning slot lines before on-board lines.
- R11: A slot line that rises while its group's enable is clear does not create a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level interrupt lines; 0..31 slot lines, 32..63 on-board lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 16 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for the map register at `addr`; 0 elsewhere |
| req_out | output | 64 | One request line per vector number |

## Verification
The bench targets several specific failure modes:
- A cleared request whose line is still high and enabled must be picked again on the rescan. A design that skips the rescan would go silent.
- Clear writes with address bit 2 low, or with a neighbouring group or vector index, must leave the request in place. A decoder that ignores bit 2 or the index would drop it.
- A second slot rise must pre-empt a pending request. A design that treats slot and on-board lines alike would keep the old vector.
- An on-board rise while a request is pending must be ignored. A design that accepts it would switch vectors.
- Simultaneous rises must resolve to the lowest index. A reversed scan would return the highest one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;
    localparam int NUM_PCI  = 32;
    localparam int NUM_OB   = 32;
    localparam int NUM_SRC  = NUM_PCI + NUM_OB;
    localparam int VEC_W    = $clog2(NUM_SRC);
    localparam int GRP_SZ   = 4;
    localparam int NUM_GRP  = NUM_PCI / GRP_SZ;
    localparam int GRP_W    = $clog2(NUM_GRP);
    localparam int OB_W     = $clog2(NUM_OB);
    localparam int EN_BIT   = DATA_W - 1;
    localparam logic [EN_BIT-1:0] OB_RST_LOW = EN_BIT'((11'h1F << 6) | 11'h20);

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } pend_t;

    typedef struct packed {
        logic             map_wr;
        logic             map_is_ob;
        logic [OB_W-1:0]  map_idx;
        logic             new_en;
        logic             pci_clr;
        logic [GRP_W-1:0] pci_clr_idx;
        logic             ob_clr;
        logic [VEC_W-1:0] ob_clr_vec;
    } wr_evt_t;

    function automatic logic [EN_BIT-1:0] ob_map_low(input logic [OB_W-1:0] idx);
        return OB_RST_LOW + EN_BIT'(idx);
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base,
                                       input int              span_bits);
        return (a >> span_bits) == (base >> span_bits);
    endfunction
endpackage

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_regdec.sv
module irqc_regdec
    import irqc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PCI_MAP_BASE = 16'h0C00,
    parameter logic [ADDR_W-1:0] OB_MAP_BASE  = 16'h1000,
    parameter logic [ADDR_W-1:0] PCI_CLR_BASE = 16'h1400,
    parameter logic [ADDR_W-1:0] OB_CLR_BASE  = 16'h1800
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output wr_evt_t           evt
);
    localparam int PCI_SPAN = GRP_W + 2;
    localparam int OB_SPAN  = OB_W + 2;
    localparam int CLR_SPAN = 8;

    logic hit_pci_map, hit_ob_map;
    logic unused_bits;

    assign unused_bits = ^{wdata[EN_BIT-1:0], addr[1:0]};
    assign hit_pci_map = in_window(addr, PCI_MAP_BASE, PCI_SPAN);
    assign hit_ob_map  = in_window(addr, OB_MAP_BASE, OB_SPAN);

    always_comb begin
        evt             = '0;
        evt.new_en      = wdata[EN_BIT];
        evt.map_is_ob   = hit_ob_map;
        evt.map_idx     = hit_ob_map ? addr[OB_SPAN-1:2] : OB_W'(addr[PCI_SPAN-1:2]);
        evt.map_wr      = wr_en && (hit_pci_map || hit_ob_map);
        evt.pci_clr     = wr_en && addr[2] && in_window(addr, PCI_CLR_BASE, CLR_SPAN);
        evt.pci_clr_idx = addr[7:5];
        evt.ob_clr      = wr_en && addr[2] && in_window(addr, OB_CLR_BASE, CLR_SPAN);
        evt.ob_clr_vec  = {1'b1, addr[7:3]};
    end
endmodule

// File: rtl/irqc_mapregs.sv
module irqc_mapregs
    import irqc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PCI_MAP_BASE = 16'h0C00,
    parameter logic [ADDR_W-1:0] OB_MAP_BASE  = 16'h1000
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_evt_t            evt,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_GRP-1:0] pci_en_q,
    output logic [NUM_SRC-1:0] src_en_nx,
    output logic [DATA_W-1:0]  rdata
);
    logic [NUM_GRP-1:0] pci_en_nx;
    logic [NUM_OB-1:0]  ob_en_q, ob_en_nx;

    always_comb begin
        pci_en_nx = pci_en_q;
        ob_en_nx  = ob_en_q;
        if (evt.map_wr) begin
            if (evt.map_is_ob) ob_en_nx[evt.map_idx]             = evt.new_en;
            else               pci_en_nx[evt.map_idx[GRP_W-1:0]] = evt.new_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pci_en_q <= '0;
            ob_en_q  <= '0;
        end else begin
            pci_en_q <= pci_en_nx;
            ob_en_q  <= ob_en_nx;
        end
    end

    for (genvar s = 0; s < NUM_PCI; s++) begin : g_pci_en
        assign src_en_nx[s] = pci_en_nx[s / GRP_SZ];
    end
    for (genvar s = 0; s < NUM_OB; s++) begin : g_ob_en
        assign src_en_nx[NUM_PCI + s] = ob_en_nx[s];
    end

    always_comb begin
        rdata = '0;
        if (in_window(addr, PCI_MAP_BASE, GRP_W + 2))
            rdata = {pci_en_q[addr[GRP_W+1:2]], {EN_BIT{1'b0}}};
        else if (in_window(addr, OB_MAP_BASE, OB_W + 2))
            rdata = {ob_en_q[addr[OB_W+1:2]], ob_map_low(addr[OB_W+1:2])};
    end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_evt_t            evt,
    input  logic [NUM_SRC-1:0] src_en_nx,
    input  logic [NUM_SRC-1:0] lvl,
    input  logic [NUM_SRC-1:0] rise,
    output pend_t              pend_q
);
    logic             scan_hit, pci_hit, ob_hit;
    logic [VEC_W-1:0] scan_idx;
    logic [4:0]       pci_idx, ob_idx;
    logic [NUM_SRC-1:0] scan_bits, rise_en;
    pend_t            pend_nx;
    logic             owns_map, drop, pci_clr_hit, ob_clr_hit, rescan;

    assign scan_bits = lvl & src_en_nx;
    assign rise_en   = rise & src_en_nx;

    irqc_pick #(.W(NUM_SRC)) u_scan (.bits(scan_bits), .hit(scan_hit), .idx(scan_idx));
    irqc_pick #(.W(NUM_PCI)) u_prise (.bits(rise_en[NUM_PCI-1:0]), .hit(pci_hit), .idx(pci_idx));
    irqc_pick #(.W(NUM_OB))  u_orise (.bits(rise_en[NUM_SRC-1:NUM_PCI]), .hit(ob_hit), .idx(ob_idx));

    always_comb begin
        owns_map = evt.map_is_ob
                 ? (pend_q.vec == {1'b1, evt.map_idx})
                 : (!pend_q.vec[VEC_W-1] && pend_q.vec[4:2] == evt.map_idx[GRP_W-1:0]);
        drop        = evt.map_wr && !evt.new_en && pend_q.valid && owns_map;
        pci_clr_hit = evt.pci_clr && pend_q.valid && !pend_q.vec[VEC_W-1]
                      && pend_q.vec[4:2] == evt.pci_clr_idx;
        ob_clr_hit  = evt.ob_clr && pend_q.valid && pend_q.vec == evt.ob_clr_vec;
        rescan      = evt.map_wr || pci_clr_hit || ob_clr_hit;

        pend_nx = pend_q;
        if (drop || pci_clr_hit || ob_clr_hit) pend_nx.valid = 1'b0;
        if (rescan && !pend_nx.valid && scan_hit) pend_nx = '{valid: 1'b1, vec: scan_idx};
        if (pci_hit)
            pend_nx = '{valid: 1'b1, vec: {1'b0, pci_idx}};
        else if (!pend_nx.valid && ob_hit)
            pend_nx = '{valid: 1'b1, vec: {1'b1, ob_idx}};
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_nx;
    end
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
    import irqc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PCI_MAP_BASE = 16'h0C00,
    parameter logic [ADDR_W-1:0] OB_MAP_BASE  = 16'h1000,
    parameter logic [ADDR_W-1:0] PCI_CLR_BASE = 16'h1400,
    parameter logic [ADDR_W-1:0] OB_CLR_BASE  = 16'h1800
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [NUM_SRC-1:0] req_out
);
    wr_evt_t            evt;
    logic [NUM_GRP-1:0] pci_en_q;
    logic [NUM_SRC-1:0] src_en_nx;
    logic [NUM_SRC-1:0] lat_q;
    pend_t              pend_q;

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= irq_in;
    end

    irqc_regdec #(
        .PCI_MAP_BASE(PCI_MAP_BASE), .OB_MAP_BASE(OB_MAP_BASE),
        .PCI_CLR_BASE(PCI_CLR_BASE), .OB_CLR_BASE(OB_CLR_BASE)
    ) u_dec (.wr_en(wr_en), .addr(addr), .wdata(wdata), .evt(evt));

    irqc_mapregs #(
        .PCI_MAP_BASE(PCI_MAP_BASE), .OB_MAP_BASE(OB_MAP_BASE)
    ) u_map (
        .clk(clk), .rst(rst), .evt(evt), .addr(addr),
        .pci_en_q(pci_en_q), .src_en_nx(src_en_nx), .rdata(rdata)
    );

    irqc_pending u_pend (
        .clk(clk), .rst(rst), .evt(evt), .src_en_nx(src_en_nx),
        .lvl(irq_in), .rise(irq_in & ~lat_q), .pend_q(pend_q)
    );

    for (genvar v = 0; v < NUM_SRC; v++) begin : g_req
        assign req_out[v] = pend_q.valid && (pend_q.vec == VEC_W'(v));
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OB_MAP_BASE = 16'h1000
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq_in,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [NUM_SRC-1:0] req_out,
    input logic [NUM_GRP-1:0] pci_en
);
    logic [1:0] armed_q;
    always_ff @(posedge clk) begin
        if (rst)                 armed_q <= 2'd0;
        else if (armed_q != 2'd2) armed_q <= armed_q + 2'd1;
    end

    assert_single_req_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_out));

    assert_hold_req_R6: assert property (@(posedge clk) disable iff (rst)
        (armed_q == 2'd2 && $past(req_out) != '0 && !$past(wr_en)
         && ($past(irq_in[NUM_PCI-1:0]) & ~$past(irq_in[NUM_PCI-1:0], 2)) == '0)
        |-> req_out == $past(req_out));

    assert_ob_disable_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (armed_q != 2'd0 && $past(wr_en && addr[ADDR_W-1:OB_W+2] == OB_MAP_BASE[ADDR_W-1:OB_W+2]
          && !wdata[EN_BIT] && req_out[{1'b1, addr[OB_W+1:2]}]))
        |-> !req_out[{1'b1, $past(addr[OB_W+1:2])}]);

    for (genvar k = 0; k < NUM_PCI; k++) begin : g_dis
        assert_dis_rise_ignored_R11: assert property (@(posedge clk) disable iff (rst)
            (armed_q == 2'd2 && !$past(wr_en) && $past(irq_in[k]) && !$past(irq_in[k], 2)
             && !$past(pci_en[k / GRP_SZ]) && !$past(req_out[k]))
            |-> !req_out[k]);
    end
endmodule

bind irq_concentrator irqc_checker #(.OB_MAP_BASE(OB_MAP_BASE)) u_chk (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .req_out(req_out), .pci_en(pci_en_q)
);

// File: tb/sim_irq_concentrator.sv
module sim_irq_concentrator;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] req_out;

    typedef struct {
        bit          is_rd;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_concentrator u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .req_out(req_out)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: compares queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it = q.pop_front();
                act = it.is_rd ? {32'b0, rdata} : req_out;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(bit is_rd, logic [63:0] exp, string tag);
        item_t it;
        it.is_rd = is_rd;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic exp_req(int vec, string tag);
        push(1'b0, (vec < 0) ? 64'd0 : (64'd1 << vec), tag);
    endtask

    task automatic reg_wr(logic [15:0] a, logic [31:0] d);
        addr = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [15:0] a, logic [31:0] exp, string tag);
        addr = a;
        push(1'b1, {32'b0, exp}, tag);
    endtask

    task automatic lines(logic [63:0] mask, bit val);
        irq_in = val ? (irq_in | mask) : (irq_in & ~mask);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        exp_req(-1, "R1 no request after reset");
        reg_rd(16'h0C00, 32'h0, "R1 slot map 0 reset");
        reg_rd(16'h1014, 32'h7E5, "R1 onboard map 5 reset");
        reg_rd(16'h107C, 32'h7FF, "R1 onboard map 31 reset");

        // R2: only the enable bit is writable
        reg_wr(16'h0C04, 32'hFFFF_FFFF);
        reg_rd(16'h0C04, 32'h8000_0000, "R2 slot map 1 enable only");
        reg_wr(16'h100C, 32'h8000_0123);
        reg_rd(16'h100C, 32'h8000_07E3, "R2 onboard map 3 low bits kept");
        reg_wr(16'h100C, 32'h0);
        reg_rd(16'h100C, 32'h0000_07E3, "R2 onboard map 3 disable");

        // R11: disabled slot group ignores a rise
        lines(64'd1 << 1, 1);
        exp_req(-1, "R11 disabled slot rise");
        // R10: enable write rescans
        reg_wr(16'h0C00, 32'h8000_0000);
        exp_req(1, "R10 rescan on enable");
        // R6: falling line keeps request
        lines(64'd1 << 1, 0);
        exp_req(1, "R6 fall keeps request");

        // R8: slot clear window
        reg_wr(16'h1400, 32'h0);
        exp_req(1, "R8 bit2 low ignored");
        reg_wr(16'h1424, 32'h0);
        exp_req(1, "R8 group mismatch ignored");
        reg_wr(16'h1404, 32'h0);
        exp_req(-1, "R8 matching clear");

        // R4: slot rise becomes pending and pre-empts
        lines(64'd1 << 5, 1);
        exp_req(5, "R4 slot rise");
        lines(64'd1 << 2, 1);
        exp_req(2, "R4 slot rise replaces pending");

        // R10 re-drive, R5 onboard rise ignored while pending
        reg_wr(16'h1000, 32'h8000_0000);
        exp_req(2, "R10 rescan keeps pending");
        lines(64'd1 << 32, 1);
        exp_req(2, "R5 onboard rise ignored while pending");

        lines(64'd1 << 2, 0);
        exp_req(2, "R6 fall keeps request");
        reg_wr(16'h1404, 32'h0);
        exp_req(5, "R10 slot before onboard on rescan");
        lines(64'd1 << 5, 0);
        reg_wr(16'h1424, 32'h0);
        exp_req(32, "R8 group 1 clear then rescan");

        // R9: onboard clear window
        reg_wr(16'h180C, 32'h0);
        exp_req(32, "R9 vector mismatch ignored");
        reg_wr(16'h1800, 32'h0);
        exp_req(32, "R9 bit2 low ignored");
        lines(64'd1 << 32, 0);
        exp_req(32, "R6 onboard fall keeps request");
        reg_wr(16'h1804, 32'h0);
        exp_req(-1, "R9 exact clear");

        // R5: onboard acceptance rules
        lines(64'd1 << 40, 1);
        exp_req(-1, "R5 disabled onboard rise");
        reg_wr(16'h1020, 32'h8000_0000);
        exp_req(40, "R10 enable onboard 8 rescans");
        lines(64'd1 << 40, 0);
        reg_wr(16'h1844, 32'h0);
        exp_req(-1, "R9 clear vector 40");
        lines(64'd1 << 32, 1);
        exp_req(32, "R5 onboard rise when idle");

        // R7: disabling the owning map entry
        lines(64'd1 << 9, 1);
        exp_req(32, "R11 disabled group 2 rise");
        reg_wr(16'h0C08, 32'h8000_0000);
        exp_req(32, "R10 enable keeps pending");
        reg_wr(16'h1000, 32'h0);
        exp_req(9, "R7 onboard disable drops and rescans");
        reg_wr(16'h0C08, 32'h0);
        exp_req(-1, "R7 slot group disable drops");

        // R10 lowest index wins among onboard lines
        lines((64'd1 << 33) | (64'd1 << 45), 1);
        exp_req(-1, "R5 two disabled onboard rises");
        reg_wr(16'h1034, 32'h8000_0000);
        exp_req(45, "R10 rescan picks 45");
        reg_wr(16'h1004, 32'h8000_0000);
        exp_req(45, "R10 re-drive pending");
        reg_wr(16'h1034, 32'h0);
        exp_req(33, "R7 drop then lowest enabled");

        // R4 simultaneous slot rises: lowest wins, pre-empts onboard
        lines((64'd1 << 3) | (64'd1 << 7), 1);
        exp_req(3, "R4 simultaneous slot rises");

        // R3: never more than one request line
        n_chk++;
        if ($countones(req_out) > 1) begin
            n_fail++;
            $display("FAIL R3 one-hot: actual %0d lines expected <=1", $countones(req_out));
        end

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule